// File: doc/BRIEF.md
# Strided Memory Command Engine

This block is a word-addressed memory server. Clients send commands on a tagged address channel. A command can be a single read, a single write, a strided write burst or a strided read burst. Every result leaves on one shared output channel. Reads return the stored word. Writes, whether single or part of a burst, return a zero token as an acknowledgment.

A burst is described by a start address, a stride and a count. Once the engine has accepted the burst command, it walks the addresses without further commands from the client. Write bursts pull one word per step from the write-data channel.

A separate descriptor channel asks the engine to stream a block of consecutive words onto the same output. Those words are flagged so that a downstream consumer can tell them apart from command replies. Descriptor streaming outranks bursts, and bursts outrank new commands.

Top module: `stride_mem_engine`

## Requirements
- R1: After reset, `outValid` is 0, `descReady` is 1, and no burst or descriptor stream is in progress. With no command offered, `cmdReady` and `wdReady` are 0.
- R2: Tag value 0 is a single read of the word at `cmdAddr`. It is accepted only when the output slot is free. On the clock edge after acceptance, `outValid` rises carrying the stored word, and `outFetch` is 0.
- R3: Tag value 1 is a single write. It is accepted only when `wdValid` is also high, and both channels transfer together. The word is stored at `cmdAddr`, and the reply is a 0 on the output. Without write data, nothing is accepted and memory is unchanged.
- R4: While `outValid` is 1 and `outReady` is 0, `outData` and `outFetch` hold steady, and no access that produces output is started. A slot that is drained in a given cycle may be refilled in that same cycle.
- R5: Tag value 2 is a write burst and tag value 3 is a read burst. Either one is accepted only when `strideValid` and `countValid` are both high. The command, stride and count then transfer in the same cycle. Loading a burst produces no output by itself.
- R6: A write burst takes `count` steps. Each step waits for write data, stores that word at the current address and emits a 0. The address then advances by the stride, modulo the memory depth.
- R7: A read burst emits, in order, the words at addr, addr+stride, and so on, `count` words in all, with addresses wrapping modulo the depth. A count of 0 emits nothing and leaves the engine free for the next command.
- R8: While a burst has steps remaining, `cmdReady` is 0.
- R9: A descriptor word carries the size in bits [5:0] and the base address in the bits directly above, from bit 6 upward, `ADDR_W` bits wide. When a descriptor is accepted, the engine emits the `size` words from base, base+1 and so on, each with `outFetch` = 1. A size of 0 emits nothing.
- R10: While a descriptor stream has words left, `descReady` is 0, and the stream takes every free output slot ahead of an active burst and ahead of new commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command taken this cycle |
| cmdTag | input | 2 | 0 read, 1 write, 2 write burst, 3 read burst |
| cmdAddr | input | ADDR_W | Word address, or burst start address |
| wdValid | input | 1 | Write data offered |
| wdReady | output | 1 | Write data taken this cycle |
| wdData | input | DATA_W | Word to store |
| strideValid | input | 1 | Stride offered |
| strideReady | output | 1 | Stride taken this cycle |
| strideData | input | ADDR_W | Address increment per burst step |
| countValid | input | 1 | Count offered |
| countReady | output | 1 | Count taken this cycle |
| countData | input | COUNT_W | Number of burst steps |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Descriptor taken this cycle when valid |
| descData | input | SIZE_W+ADDR_W | {base, size} descriptor |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Consumer accepts output |
| outData | output | DATA_W | Read word, or 0 for a write acknowledgment |
| outFetch | output | 1 | Word comes from a descriptor stream |

## Verification
The bench stalls the output and then offers a second read. A design that ignored the full slot would accept that read and overwrite the held word. A design that waited a cycle too long after the slot drained would also be caught.

Burst addresses are chosen so that one burst crosses the top of the memory. A design that saturated or carried the address would write or read the wrong words. Zero-count bursts and zero-size descriptors are tested, since an engine that decremented before testing would run for a full wrap. The bench also starts a descriptor stream under a burst that is stalled partway through, and checks that the streamed words come first. A design with the ranking reversed would interleave the two sources or finish the burst first.

// File: rtl/stride_mem_pkg.sv
`timescale 1ns/1ps
package stride_mem_pkg;

  typedef enum logic [1:0] {
    TAG_READ  = 2'd0,
    TAG_WRITE = 2'd1,
    TAG_WMANY = 2'd2,
    TAG_RMANY = 2'd3
  } cmd_tag_e;

  // strobes from control to datapath for one memory access
  typedef struct packed {
    logic re;
    logic we;
    logic ackZero;
    logic fromFetch;
  } mem_strobe_t;

endpackage

// File: rtl/stride_mem_seq.sv
`timescale 1ns/1ps
// address walker: loads (start, stride, count), advances one step per strobe
module stride_mem_seq #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic [AW-1:0] loadAddr,
  input  logic [AW-1:0] loadStride,
  input  logic [CW-1:0] loadCount,
  input  logic          step,
  output logic [AW-1:0] curAddr,
  output logic          busy
);

  logic [AW-1:0] strideQ;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      strideQ <= '0;
      left    <= '0;
    end else if (load) begin
      curAddr <= loadAddr;
      strideQ <= loadStride;
      left    <= loadCount;
    end else if (step) begin
      curAddr <= curAddr + strideQ;
      left    <= left - 1'b1;
    end
  end

  assign busy = (left != '0);

  // R6: a step is only taken while work remains
  a_r6_step_busy: assert property (@(posedge clk) disable iff (!rstN)
    step |-> busy);

  // R7: each step lowers the remaining count by exactly one
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load) |=> (left == $past(left) - 1'b1));

endmodule

// File: rtl/stride_mem_dpath.sv
`timescale 1ns/1ps
module stride_mem_dpath
  import stride_mem_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  mem_strobe_t   strobe,
  input  logic [AW-1:0] memAddr,
  input  logic [DW-1:0] wdData,
  input  logic          outReady,
  output logic          outValid,
  output logic [DW-1:0] outData,
  output logic          outFetch
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ramQ;
  logic          ackZeroQ;

  // synchronous RAM: one write or one registered read per cycle
  always_ff @(posedge clk) begin
    if (strobe.we) mem[memAddr] <= wdData;
    if (strobe.re) ramQ <= mem[memAddr];
  end

  // single output slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      ackZeroQ <= 1'b0;
      outFetch <= 1'b0;
    end else if (strobe.re || strobe.we) begin
      outValid <= 1'b1;
      ackZeroQ <= strobe.ackZero;
      outFetch <= strobe.fromFetch;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assign outData = ackZeroQ ? '0 : ramQ;

  // R4: a stalled word stays put
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outFetch)));

  // R4: no access that fills the slot while it is full and stalled
  a_r4_no_issue_full: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !(strobe.re || strobe.we));

  // R3: a write answers with a zero token one cycle later
  a_r3_ack_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.we |=> (outValid && outData == '0));

  // R2: a read produces a valid word one cycle later
  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.re |=> outValid);

endmodule

// File: rtl/stride_mem_ctrl.sv
`timescale 1ns/1ps
module stride_mem_ctrl
  import stride_mem_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int SW = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdTag,
  input  logic [AW-1:0]    cmdAddr,
  input  logic             wdValid,
  output logic             wdReady,
  input  logic             strideValid,
  output logic             strideReady,
  input  logic [AW-1:0]    strideData,
  input  logic             countValid,
  output logic             countReady,
  input  logic [CW-1:0]    countData,
  input  logic             descValid,
  output logic             descReady,
  input  logic [SW+AW-1:0] descData,
  input  logic             outValid,
  input  logic             outReady,
  output mem_strobe_t      strobe,
  output logic [AW-1:0]    memAddr
);

  localparam logic [AW-1:0] UNIT_STRIDE = AW'(1);

  cmd_tag_e      tag;
  logic          slotFree, cmdOpen;
  logic          fetchBusy, burstBusy, burstWrite;
  logic          descFire, fetchStep, burstStep;
  logic          rdGo, wrGo, loadGo;
  logic [AW-1:0] fetchAddr, burstAddr;

  assign tag = cmd_tag_e'(cmdTag);

  // fixed ranking: descriptor stream, then burst, then new command
  always_comb begin
    slotFree  = !outValid || outReady;
    descFire  = descValid && !fetchBusy;
    fetchStep = fetchBusy && slotFree;
    burstStep = !fetchBusy && burstBusy && slotFree && (!burstWrite || wdValid);
    cmdOpen   = !fetchBusy && !burstBusy && cmdValid;
    rdGo      = cmdOpen && (tag == TAG_READ) && slotFree;
    wrGo      = cmdOpen && (tag == TAG_WRITE) && slotFree && wdValid;
    loadGo    = cmdOpen && ((tag == TAG_WMANY) || (tag == TAG_RMANY))
                && strideValid && countValid;
  end

  assign descReady   = !fetchBusy;
  assign cmdReady    = rdGo || wrGo || loadGo;
  assign wdReady     = wrGo || (burstStep && burstWrite);
  assign strideReady = loadGo;
  assign countReady  = loadGo;

  always_comb begin
    strobe.re        = fetchStep || rdGo || (burstStep && !burstWrite);
    strobe.we        = wrGo || (burstStep && burstWrite);
    strobe.ackZero   = strobe.we;
    strobe.fromFetch = fetchStep;
    if (fetchStep)      memAddr = fetchAddr;
    else if (burstStep) memAddr = burstAddr;
    else                memAddr = cmdAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       burstWrite <= 1'b0;
    else if (loadGo) burstWrite <= (tag == TAG_WMANY);
  end

  stride_mem_seq #(.AW(AW), .CW(SW)) fetchSeq (
    .clk(clk), .rstN(rstN),
    .load(descFire), .loadAddr(descData[SW +: AW]),
    .loadStride(UNIT_STRIDE), .loadCount(descData[SW-1:0]),
    .step(fetchStep), .curAddr(fetchAddr), .busy(fetchBusy)
  );

  stride_mem_seq #(.AW(AW), .CW(CW)) burstSeq (
    .clk(clk), .rstN(rstN),
    .load(loadGo), .loadAddr(cmdAddr),
    .loadStride(strideData), .loadCount(countData),
    .step(burstStep), .curAddr(burstAddr), .busy(burstBusy)
  );

  // R8: no command accepted while a burst runs
  a_r8_no_cmd_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    burstBusy |-> !cmdReady);

  // R10: a running descriptor stream blocks commands and burst data
  a_r10_fetch_first: assert property (@(posedge clk) disable iff (!rstN)
    fetchBusy |-> (!cmdReady && !wdReady && !descReady));

  // R5: stride and count always move together with the command
  a_r5_together: assert property (@(posedge clk) disable iff (!rstN)
    (strideReady || countReady) |-> (strideReady && countReady && cmdReady));

endmodule

// File: rtl/stride_mem_engine.sv
`timescale 1ns/1ps
module stride_mem_engine
  import stride_mem_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 8,
  parameter int SIZE_W  = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  output logic                     cmdReady,
  input  logic [1:0]               cmdTag,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic                     wdValid,
  output logic                     wdReady,
  input  logic [DATA_W-1:0]        wdData,
  input  logic                     strideValid,
  output logic                     strideReady,
  input  logic [ADDR_W-1:0]        strideData,
  input  logic                     countValid,
  output logic                     countReady,
  input  logic [COUNT_W-1:0]       countData,
  input  logic                     descValid,
  output logic                     descReady,
  input  logic [SIZE_W+ADDR_W-1:0] descData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [DATA_W-1:0]        outData,
  output logic                     outFetch
);

  mem_strobe_t       strobe;
  logic [ADDR_W-1:0] memAddr;

  stride_mem_ctrl #(.AW(ADDR_W), .CW(COUNT_W), .SW(SIZE_W)) ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdTag(cmdTag), .cmdAddr(cmdAddr),
    .wdValid(wdValid), .wdReady(wdReady),
    .strideValid(strideValid), .strideReady(strideReady), .strideData(strideData),
    .countValid(countValid), .countReady(countReady), .countData(countData),
    .descValid(descValid), .descReady(descReady), .descData(descData),
    .outValid(outValid), .outReady(outReady),
    .strobe(strobe), .memAddr(memAddr)
  );

  stride_mem_dpath #(.AW(ADDR_W), .DW(DATA_W)) dpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .memAddr(memAddr), .wdData(wdData),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outFetch(outFetch)
  );

endmodule

// File: tb/stride_mem_engine_test.sv
`timescale 1ns/1ps
module stride_mem_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 0, wdValid = 0, strideValid = 0, countValid = 0, descValid = 0;
  logic        outReady = 1;
  logic [1:0]  cmdTag = 0;
  logic [7:0]  cmdAddr = 0, strideData = 0, countData = 0;
  logic [31:0] wdData = 0;
  logic [13:0] descData = 0;
  logic        cmdReady, wdReady, strideReady, countReady, descReady, outValid, outFetch;
  logic [31:0] outData;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  stride_mem_engine uut (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdTag(cmdTag), .cmdAddr(cmdAddr),
    .wdValid(wdValid), .wdReady(wdReady), .wdData(wdData),
    .strideValid(strideValid), .strideReady(strideReady), .strideData(strideData),
    .countValid(countValid), .countReady(countReady), .countData(countData),
    .descValid(descValid), .descReady(descReady), .descData(descData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outFetch(outFetch)
  );

  // log of every output transfer
  logic [31:0] logData [256];
  logic        logFetch [256];
  int          logN = 0;

  always @(posedge clk) begin
    if (rstN && outValid && outReady && logN < 256) begin
      logData[logN]  <= outData;
      logFetch[logN] <= outFetch;
      logN           <= logN + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putCmd(input logic [1:0] tag, input logic [7:0] a, input logic useWd,
                        input logic [31:0] wd, input logic useSc, input logic [7:0] st,
                        input logic [7:0] cnt);
    @(negedge clk);
    cmdValid = 1; cmdTag = tag; cmdAddr = a; wdValid = useWd; wdData = wd;
    strideValid = useSc; strideData = st; countValid = useSc; countData = cnt;
    #1;
    while (!cmdReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmdValid = 0; wdValid = 0; strideValid = 0; countValid = 0;
  endtask

  task automatic putWd(input logic [31:0] wd);
    @(negedge clk);
    wdValid = 1; wdData = wd;
    #1;
    while (!wdReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wdValid = 0;
  endtask

  task automatic putDesc(input logic [7:0] base, input logic [5:0] size);
    @(negedge clk);
    descValid = 1; descData = {base, size};
    #1;
    while (!descReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    descValid = 0;
  endtask

  task automatic waitLog(input int n);
    while (logN < n) @(negedge clk);
  endtask

  // table: {isWrite, addr, data (stored, or expected for reads)}
  localparam logic [40:0] VEC [8] = '{
    {1'b1, 8'd3,   32'h1111_1111},
    {1'b1, 8'd4,   32'h2222_2222},
    {1'b0, 8'd3,   32'h1111_1111},
    {1'b1, 8'd255, 32'hDEAD_BEEF},
    {1'b0, 8'd4,   32'h2222_2222},
    {1'b0, 8'd255, 32'hDEAD_BEEF},
    {1'b1, 8'd3,   32'h3333_3333},
    {1'b0, 8'd3,   32'h3333_3333}
  };

  logic done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #1;
    // R1 reset state
    chk("R1 outValid", 32'(outValid), 0);
    chk("R1 descReady", 32'(descReady), 1);
    chk("R1 cmdReady", 32'(cmdReady), 0);
    chk("R1 wdReady", 32'(wdReady), 0);

    // R2 / R3 vector walk
    for (int i = 0; i < 8; i++) begin
      logic [40:0] v;
      v = VEC[i];
      base = logN;
      if (v[40]) putCmd(2'd1, v[39:32], 1, v[31:0], 0, 0, 0);
      else       putCmd(2'd0, v[39:32], 0, 0, 0, 0, 0);
      waitLog(base + 1);
      if (v[40]) chk("R3 write ack", logData[base], 32'h0);
      else       chk("R2 read data", logData[base], v[31:0]);
      chk("R2 outFetch", 32'(logFetch[base]), 0);
    end

    // R3 write without data is not taken
    @(negedge clk);
    cmdValid = 1; cmdTag = 2'd1; cmdAddr = 8'd4; wdValid = 0; wdData = 32'h9999_9999;
    for (int k = 0; k < 3; k++) begin
      #1; chk("R3 no data no accept", 32'(cmdReady), 0);
      @(negedge clk);
    end
    cmdValid = 0;
    base = logN;
    putCmd(2'd0, 8'd4, 0, 0, 0, 0, 0);
    waitLog(base + 1);
    chk("R3 memory unchanged", logData[base], 32'h2222_2222);

    // R4 backpressure
    @(negedge clk); outReady = 0;
    putCmd(2'd0, 8'd3, 0, 0, 0, 0, 0);
    chk("R2 valid next cycle", 32'(outValid), 1);
    chk("R2 latency data", outData, 32'h3333_3333);
    @(negedge clk);
    cmdValid = 1; cmdTag = 2'd0; cmdAddr = 8'd255;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R4 no accept when full", 32'(cmdReady), 0);
      chk("R4 data held", outData, 32'h3333_3333);
      @(negedge clk);
    end
    outReady = 1; #1;
    chk("R4 slot refills same cycle", 32'(cmdReady), 1);
    @(posedge clk); #1;
    cmdValid = 0;
    chk("R4 next word", outData, 32'hDEAD_BEEF);
    repeat (3) @(posedge clk);

    // R5 burst needs both stride and count
    @(negedge clk);
    cmdValid = 1; cmdTag = 2'd3; cmdAddr = 8'd20; strideValid = 1; countValid = 0;
    #1;
    chk("R5 count missing cmdReady", 32'(cmdReady), 0);
    chk("R5 count missing strideReady", 32'(strideReady), 0);
    cmdValid = 0; strideValid = 0;

    // R6 write burst at 20 stride 3 count 4
    putCmd(2'd2, 8'd20, 0, 0, 1, 8'd3, 8'd4);
    base = logN;
    repeat (3) @(posedge clk);
    chk("R5 load emits nothing", 32'(logN - base), 0);
    @(negedge clk);
    cmdValid = 1; cmdTag = 2'd0; cmdAddr = 8'd3; #1;
    chk("R8 no cmd during burst", 32'(cmdReady), 0);
    cmdValid = 0;
    for (int k = 0; k < 4; k++) putWd(32'h50 + 32'(k));
    waitLog(base + 4);
    for (int k = 0; k < 4; k++) chk("R6 burst ack", logData[base + k], 32'h0);
    for (int k = 0; k < 4; k++) begin
      base = logN;
      putCmd(2'd0, 8'(20 + 3 * k), 0, 0, 0, 0, 0);
      waitLog(base + 1);
      chk("R6 burst stored", logData[base], 32'h50 + 32'(k));
    end

    // R6 wrap: 250, 255, 4
    putCmd(2'd2, 8'd250, 0, 0, 1, 8'd5, 8'd3);
    base = logN;
    for (int k = 0; k < 3; k++) putWd(32'h60 + 32'(k));
    waitLog(base + 3);
    base = logN;
    putCmd(2'd0, 8'd4, 0, 0, 0, 0, 0);
    waitLog(base + 1);
    chk("R6 wrapped store", logData[base], 32'h62);

    // R7 read burst with wrap
    base = logN;
    putCmd(2'd3, 8'd250, 0, 0, 1, 8'd5, 8'd3);
    waitLog(base + 3);
    for (int k = 0; k < 3; k++) chk("R7 wrap read", logData[base + k], 32'h60 + 32'(k));
    base = logN;
    putCmd(2'd3, 8'd20, 0, 0, 1, 8'd3, 8'd4);
    waitLog(base + 4);
    for (int k = 0; k < 4; k++) chk("R7 read burst", logData[base + k], 32'h50 + 32'(k));

    // R7 zero count
    base = logN;
    putCmd(2'd3, 8'd20, 0, 0, 1, 8'd1, 8'd0);
    putCmd(2'd0, 8'd3, 0, 0, 0, 0, 0);
    waitLog(base + 1);
    chk("R7 zero count emits nothing", logData[base], 32'h3333_3333);

    // R9 descriptor stream
    putCmd(2'd2, 8'd100, 0, 0, 1, 8'd1, 8'd6);
    base = logN;
    for (int k = 0; k < 6; k++) putWd(32'hA0 + 32'(k));
    waitLog(base + 6);
    base = logN;
    putDesc(8'd100, 6'd6);
    waitLog(base + 6);
    for (int k = 0; k < 6; k++) begin
      chk("R9 fetch data", logData[base + k], 32'hA0 + 32'(k));
      chk("R9 fetch flag", 32'(logFetch[base + k]), 1);
    end
    base = logN;
    putDesc(8'd100, 6'd0);
    repeat (4) @(posedge clk);
    #1;
    chk("R9 size zero emits nothing", 32'(logN - base), 0);
    chk("R9 size zero idle", 32'(descReady), 1);

    // R10 stream preempts a stalled burst
    @(negedge clk); outReady = 0;
    putCmd(2'd3, 8'd20, 0, 0, 1, 8'd3, 8'd4);
    base = logN;
    repeat (2) @(posedge clk);
    putDesc(8'd100, 6'd2);
    chk("R10 descReady low while streaming", 32'(descReady), 0);
    @(negedge clk); outReady = 1;
    waitLog(base + 6);
    chk("R10 order 0", logData[base + 0], 32'h50);
    chk("R10 order 1", logData[base + 1], 32'hA0);
    chk("R10 order 2", logData[base + 2], 32'hA1);
    chk("R10 order 3", logData[base + 3], 32'h51);
    chk("R10 order 4", logData[base + 4], 32'h52);
    chk("R10 order 5", logData[base + 5], 32'h53);
    chk("R10 flag fetch", 32'(logFetch[base + 1]), 1);
    chk("R10 flag burst", 32'(logFetch[base + 3]), 0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule